// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is the data register that a JTAG TAP selects to reach a core's debug registers. Each scan moves one 38-bit frame through it, least significant bit first. The frame holds a 32-bit data word, then a 5-bit register address, then a single direction bit. When the TAP reaches Update-DR, the block either writes the data word into the addressed register or records a read request. A read is pipelined. The addressed register is copied into a read buffer at update time, and that buffer is loaded into the chain at the next Capture-DR. The value therefore comes out on the following scan.

Behind the chain sit the following registers:
- a debug control register, whose bit 4 enables monitor mode;
- a read-only debug status register, fed by a side port;
- a vector-catch register;
- two watchpoint units, each with six 32-bit value/mask registers;
- a pair of communication mailboxes with a control word.

The core side of the mailboxes uses a valid/ready handshake in each direction. A read of the core-to-host data word consumes that word. Reading the mailbox control word has no side effect, so the final scan of a transfer should name the control word.

Top module: `dbg_scan_chain`

## Requirements
- R1: Frame bit positions are fixed. Bit 0 is shifted in and out first. Bits 31:0 carry data, bits 36:32 carry the address and bit 37 is the write flag. The chain is 38 stages long, so the bits shifted out mirror the captured frame in the same positions.
- R2: An update with the write flag at 1 loads bits 31:0 into the addressed writable register. The change is visible on the register's output port one cycle after the update.
- R3: An update with the write flag at 0 copies the addressed register into a read buffer. The next capture loads that buffer into bits 31:0 and zeros into bits 37:32. A write does not disturb the buffer.
- R4: Addresses are as follows: 0x00 debug control, 0x01 debug status, 0x02 vector catch, 0x04 mailbox control and 0x05 mailbox data. Watchpoint unit u occupies addresses 8·(u+1)+k for k = 0..5, in the order address value, address mask, data value, data mask, control value, control mask. `wp_regs` bits [(6u+k)·32 +: 32] carry that register.
- R5: Debug control is 6 bits wide and reads back zero-extended, so higher written bits are dropped. Its bit 4 drives `mon_en`.
- R6: Debug status reads `status_in` zero-extended, and writes to address 0x01 have no effect.
- R7: The mailbox control word reads bit 0 = host-to-core full, bit 1 = core-to-host full, bits 27:2 = 0 and bits 31:28 = the VERSION parameter. Writes to it are ignored.
- R8: A write to mailbox data sets the host-to-core full flag and presents the word on `h2c_data` with `h2c_valid` high. A core handshake (`h2c_valid && h2c_ready`) clears the flag on the next cycle.
- R9: A core push (`c2h_valid && c2h_ready`) stores the word and sets the core-to-host full flag, and `c2h_ready` is low while the flag is set. A read request of mailbox data clears the flag and returns the word on the next scan. A read of mailbox control leaves the flag alone.
- R10: Reads of unmapped addresses return zero, and writes to them change no register.
- R11: Reset clears all registers, the read buffer and both mailbox flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| tlr | input | 1 | Synchronous test-logic reset, active high |
| capture_en | input | 1 | Capture-DR strobe |
| shift_en | input | 1 | Shift-DR strobe |
| update_en | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| status_in | input | 5 | Core status bits for the status register |
| h2c_valid | output | 1 | Host-to-core word available |
| h2c_data | output | 32 | Host-to-core word |
| h2c_ready | input | 1 | Core takes the host-to-core word |
| c2h_valid | input | 1 | Core offers a word to the host |
| c2h_data | input | 32 | Core-to-host word |
| c2h_ready | output | 1 | Core-to-host mailbox empty |
| dbg_ctrl | output | 6 | Debug control register |
| mon_en | output | 1 | Monitor-mode enable (debug control bit 4) |
| vcatch | output | 32 | Vector-catch register |
| wp_regs | output | 384 | Watchpoint registers, unit-major, slot-minor |

## Verification
Because reads are pipelined, a wrong read buffer or a wrong decode only shows up one scan later, in the data field of the next frame. A wrong header at capture shows up in bits 37:32 of that same frame. A mailbox flag stuck at the wrong value shows up immediately on `h2c_valid` or `c2h_ready`, and on the next mailbox-control read. A read that consumes a word when it should not shows up as `c2h_ready` rising one cycle after that update. A decode that writes the wrong register is caught at the register output ports one cycle after the update, and again when the register is read back.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_CTRL = 5'h00;
  localparam logic [AW-1:0] A_STAT = 5'h01;
  localparam logic [AW-1:0] A_VCAT = 5'h02;
  localparam logic [AW-1:0] A_CCTL = 5'h04;
  localparam logic [AW-1:0] A_CDAT = 5'h05;

  function automatic logic [DW-1:0] comms_word(input logic [3:0] ver,
                                               input logic w_full,
                                               input logic r_full);
    return {ver, 26'b0, w_full, r_full};
  endfunction

  function automatic logic [AW-1:0] wp_addr(input int unit, input int slot);
    return AW'((unit + 1) * 8 + slot);
  endfunction
endpackage

// File: rtl/dbg_shift_chain.sv
module dbg_shift_chain #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              tlr,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output logic              tdo,
  output logic              upd_fire,
  output logic              upd_wr,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [DATA_W-1:0] upd_data
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (tlr) sr <= '0;
    else if (capture_en) sr <= {{(ADDR_W+1){1'b0}}, cap_data};
    else if (shift_en) sr <= {tdi, sr[FRAME_W-1:1]};
  end

  assign tdo      = sr[0];
  assign upd_fire = update_en;
  assign upd_wr   = sr[FRAME_W-1];
  assign upd_addr = sr[DATA_W +: ADDR_W];
  assign upd_data = sr[DATA_W-1:0];

  p_cap_hdr_zero_r3: assert property (@(posedge clk) disable iff (tlr)
    capture_en |=> (sr[FRAME_W-1:DATA_W] == '0));
  p_shift_in_top_r1: assert property (@(posedge clk) disable iff (tlr)
    (shift_en && !capture_en) |=> (sr[FRAME_W-1] == $past(tdi)));
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_scan_pkg::*;
#(
  parameter int CTRL_W   = 6,
  parameter int NUM_WP   = 2,
  parameter int WP_SLOTS = 6
) (
  input  logic                          clk,
  input  logic                          tlr,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  input  logic [AW-1:0]                 raddr,
  output logic [DW-1:0]                 rdata,
  output logic [CTRL_W-1:0]             ctrl_q,
  output logic [DW-1:0]                 vcat_q,
  output logic [NUM_WP*WP_SLOTS*DW-1:0] wp_flat
);
  logic [DW-1:0] wp_q [NUM_WP][WP_SLOTS];

  always_ff @(posedge clk) begin
    if (tlr) begin
      ctrl_q <= '0;
      vcat_q <= '0;
    end else if (we) begin
      if (addr == A_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
      if (addr == A_VCAT) vcat_q <= wdata;
    end
  end

  for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
    for (genvar k = 0; k < WP_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (tlr) wp_q[u][k] <= '0;
        else if (we && addr == wp_addr(u, k)) wp_q[u][k] <= wdata;
      end
      assign wp_flat[(u*WP_SLOTS+k)*DW +: DW] = wp_q[u][k];
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr == A_CTRL) rdata = DW'(ctrl_q);
    if (raddr == A_VCAT) rdata = vcat_q;
    for (int u = 0; u < NUM_WP; u++)
      for (int k = 0; k < WP_SLOTS; k++)
        if (raddr == wp_addr(u, k)) rdata = wp_q[u][k];
  end

  p_ctrl_write_r5: assert property (@(posedge clk) disable iff (tlr)
    (we && addr == A_CTRL) |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (tlr)
    !(we && addr == A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              tlr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic              r_full,
  output logic              w_full,
  output logic [DATA_W-1:0] c2h_word,
  output logic              h2c_valid,
  output logic [DATA_W-1:0] h2c_data,
  input  logic              h2c_ready,
  input  logic              c2h_valid,
  input  logic [DATA_W-1:0] c2h_data,
  output logic              c2h_ready
);
  logic h2c_take, c2h_push;
  assign h2c_take = r_full & h2c_ready;
  assign c2h_push = c2h_valid & ~w_full;

  always_ff @(posedge clk) begin
    if (tlr) begin
      r_full   <= 1'b0;
      w_full   <= 1'b0;
      h2c_data <= '0;
      c2h_word <= '0;
    end else begin
      if (host_wr) begin
        r_full   <= 1'b1;
        h2c_data <= host_wdata;
      end else if (h2c_take) begin
        r_full <= 1'b0;
      end
      if (c2h_push) begin
        w_full   <= 1'b1;
        c2h_word <= c2h_data;
      end else if (host_rd) begin
        w_full <= 1'b0;
      end
    end
  end

  assign h2c_valid = r_full;
  assign c2h_ready = ~w_full;

  p_host_wr_sets_r8: assert property (@(posedge clk) disable iff (tlr)
    host_wr |=> h2c_valid);
  p_core_take_clears_r8: assert property (@(posedge clk) disable iff (tlr)
    (h2c_valid && h2c_ready && !host_wr) |=> !h2c_valid);
  p_push_fills_r9: assert property (@(posedge clk) disable iff (tlr)
    (c2h_valid && c2h_ready) |=> !c2h_ready);
  p_full_holds_r9: assert property (@(posedge clk) disable iff (tlr)
    (!c2h_ready && !host_rd) |=> (!c2h_ready && $stable(c2h_word)));
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
  import dbg_scan_pkg::*;
#(
  parameter logic [3:0] VERSION  = 4'h2,
  parameter int         CTRL_W   = 6,
  parameter int         STAT_W   = 5,
  parameter int         NUM_WP   = 2,
  parameter int         WP_SLOTS = 6
) (
  input  logic                          clk,
  input  logic                          tlr,
  input  logic                          capture_en,
  input  logic                          shift_en,
  input  logic                          update_en,
  input  logic                          tdi,
  output logic                          tdo,
  input  logic [STAT_W-1:0]             status_in,
  output logic                          h2c_valid,
  output logic [DW-1:0]                 h2c_data,
  input  logic                          h2c_ready,
  input  logic                          c2h_valid,
  input  logic [DW-1:0]                 c2h_data,
  output logic                          c2h_ready,
  output logic [CTRL_W-1:0]             dbg_ctrl,
  output logic                          mon_en,
  output logic [DW-1:0]                 vcatch,
  output logic [NUM_WP*WP_SLOTS*DW-1:0] wp_regs
);
  localparam int MON_BIT = 4;

  logic          upd_fire, upd_wr;
  logic [AW-1:0] upd_addr;
  logic [DW-1:0] upd_data, read_buf, bank_rdata, rd_value, c2h_word;
  logic          r_full, w_full, host_wr, host_rd, rd_req;

  dbg_shift_chain #(.DATA_W(DW), .ADDR_W(AW)) u_chain (
    .clk(clk), .tlr(tlr), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .tdi(tdi), .cap_data(read_buf), .tdo(tdo),
    .upd_fire(upd_fire), .upd_wr(upd_wr), .upd_addr(upd_addr),
    .upd_data(upd_data));

  dbg_reg_bank #(.CTRL_W(CTRL_W), .NUM_WP(NUM_WP), .WP_SLOTS(WP_SLOTS)) u_bank (
    .clk(clk), .tlr(tlr), .we(upd_fire & upd_wr), .addr(upd_addr),
    .wdata(upd_data), .raddr(upd_addr), .rdata(bank_rdata),
    .ctrl_q(dbg_ctrl), .vcat_q(vcatch), .wp_flat(wp_regs));

  assign rd_req  = upd_fire & ~upd_wr;
  assign host_wr = upd_fire & upd_wr & (upd_addr == A_CDAT);
  assign host_rd = rd_req & (upd_addr == A_CDAT);

  dbg_mailbox #(.DATA_W(DW)) u_mbox (
    .clk(clk), .tlr(tlr), .host_wr(host_wr), .host_wdata(upd_data),
    .host_rd(host_rd), .r_full(r_full), .w_full(w_full), .c2h_word(c2h_word),
    .h2c_valid(h2c_valid), .h2c_data(h2c_data), .h2c_ready(h2c_ready),
    .c2h_valid(c2h_valid), .c2h_data(c2h_data), .c2h_ready(c2h_ready));

  always_comb begin
    case (upd_addr)
      A_STAT:  rd_value = DW'(status_in);
      A_CCTL:  rd_value = comms_word(VERSION, w_full, r_full);
      A_CDAT:  rd_value = c2h_word;
      default: rd_value = bank_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tlr) read_buf <= '0;
    else if (rd_req) read_buf <= rd_value;
  end

  assign mon_en = dbg_ctrl[MON_BIT];

  p_rdbuf_hold_r3: assert property (@(posedge clk) disable iff (tlr)
    !rd_req |=> $stable(read_buf));
  p_cctl_read_safe_r9: assert property (@(posedge clk) disable iff (tlr)
    (rd_req && upd_addr == A_CCTL && !c2h_ready) |=> !c2h_ready);
  p_cctl_version_r7: assert property (@(posedge clk) disable iff (tlr)
    (rd_req && upd_addr == A_CCTL) |=> (read_buf[31:28] == VERSION && read_buf[27:2] == '0));
endmodule

// File: tb/dbg_scan_chain_test.sv
module dbg_scan_chain_test;
  localparam logic [3:0] VER = 4'h2;

  logic clk = 0, tlr = 1, capture_en = 0, shift_en = 0, update_en = 0, tdi = 0;
  logic tdo;
  logic [4:0] status_in = 0;
  logic h2c_valid, h2c_ready = 0, c2h_valid = 0, c2h_ready;
  logic [31:0] h2c_data, c2h_data = 0, vcatch;
  logic [5:0] dbg_ctrl;
  logic mon_en;
  logic [383:0] wp_regs;
  int errors = 0, checks = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;

  dbg_scan_chain #(.VERSION(VER)) uut (
    .clk(clk), .tlr(tlr), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .tdi(tdi), .tdo(tdo), .status_in(status_in),
    .h2c_valid(h2c_valid), .h2c_data(h2c_data), .h2c_ready(h2c_ready),
    .c2h_valid(c2h_valid), .c2h_data(c2h_data), .c2h_ready(c2h_ready),
    .dbg_ctrl(dbg_ctrl), .mon_en(mon_en), .vcatch(vcatch), .wp_regs(wp_regs));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic scan(input logic [31:0] d, input logic [4:0] a, input logic w,
                      output logic [37:0] got);
    logic [37:0] f;
    f = {w, a, d};
    @(negedge clk) capture_en = 1;
    @(negedge clk) capture_en = 0; shift_en = 1;
    for (int i = 0; i < 38; i++) begin
      tdi = f[i];
      #1 got[i] = tdo;
      @(negedge clk);
    end
    shift_en = 0; update_en = 1;
    @(negedge clk) update_en = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] g;
    scan(d, a, 1'b1, g);
  endtask

  // Read: request on one scan, collect on the next (which names the safe control word).
  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    logic [37:0] g;
    scan(32'h0, a, 1'b0, g);
    scan(32'h0, 5'h04, 1'b0, g);
    v = g[31:0];
  endtask

  task automatic do_reset;
    @(negedge clk) tlr = 1;
    repeat (2) @(negedge clk);
    tlr = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [37:0] g;
    do_reset();
    scan(32'h0, 5'h04, 1'b0, g);
    check("R11 read buffer after reset", g, 38'h0);
    check("R11 h2c_valid", h2c_valid, 0);
    check("R11 c2h_ready", c2h_ready, 1);
    check("R11 dbg_ctrl", dbg_ctrl, 0);
    check("R11 wp_regs", wp_regs[63:0], 0);
    rd(5'h04, v);
    check("R7 control word after reset", v, {VER, 28'h0});
  endtask

  task automatic t_frame;
    logic [37:0] g;
    wr(5'h02, 32'hA5A5_1234);
    check("R2 vcatch port", vcatch, 32'hA5A5_1234);
    scan(32'hFFFF_FFFF, 5'h02, 1'b0, g);
    scan(32'h0, 5'h1F, 1'b0, g);
    check("R3 pipelined read data", g[31:0], 32'hA5A5_1234);
    check("R1 header bits zero at capture", g[37:32], 0);
    scan(32'h0, 5'h02, 1'b1, g);
    check("R3 unmapped read lands next scan", g, 38'h0);
    check("R1 write flag at bit 37 took effect", vcatch, 0);
  endtask

  task automatic t_watch;
    logic [31:0] v;
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 6; k++)
        wr(5'((u + 1) * 8 + k), 32'h1000_0000 * (u + 1) + k * 32'h11);
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 6; k++) begin
        rd(5'((u + 1) * 8 + k), v);
        check("R4 watchpoint readback", v, 32'h1000_0000 * (u + 1) + k * 32'h11);
        check("R4 wp_regs slice", wp_regs[(u*6+k)*32 +: 32], 32'h1000_0000 * (u + 1) + k * 32'h11);
      end
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v);
    check("R5 ctrl width", v, 32'h3F);
    check("R5 mon_en set", mon_en, 1);
    wr(5'h00, 32'h0000_000F);
    check("R5 mon_en clear", mon_en, 0);
    check("R2 ctrl port", dbg_ctrl, 6'h0F);
  endtask

  task automatic t_status;
    logic [31:0] v;
    status_in = 5'h15;
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h01, v);
    check("R6 status read", v, 32'h15);
    check("R6 write ignored, ctrl intact", dbg_ctrl, 6'h0F);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(5'h03, 32'hCAFE_0003);
    wr(5'h1F, 32'hCAFE_001F);
    wr(5'h0E, 32'hCAFE_000E);
    rd(5'h03, v);
    check("R10 unmapped 0x03 reads zero", v, 0);
    rd(5'h1F, v);
    check("R10 unmapped 0x1F reads zero", v, 0);
    check("R10 vcatch untouched", vcatch, 0);
    check("R10 ctrl untouched", dbg_ctrl, 6'h0F);
    check("R10 wp1 control mask untouched", wp_regs[11*32 +: 32], 32'h2000_0055);
  endtask

  task automatic t_h2c;
    logic [31:0] v;
    wr(5'h05, 32'hDEAD_BEEF);
    check("R8 h2c_valid", h2c_valid, 1);
    check("R8 h2c_data", h2c_data, 32'hDEAD_BEEF);
    rd(5'h04, v);
    check("R8 control R flag set", v, {VER, 26'h0, 2'b01});
    @(negedge clk) h2c_ready = 1;
    @(negedge clk) h2c_ready = 0;
    check("R8 h2c_valid cleared", h2c_valid, 0);
    rd(5'h04, v);
    check("R8 control R flag clear", v, {VER, 28'h0});
  endtask

  task automatic t_c2h;
    logic [31:0] v;
    logic [37:0] g;
    @(negedge clk) c2h_valid = 1; c2h_data = 32'h0000_1357;
    @(negedge clk) c2h_valid = 0;
    check("R9 c2h_ready low", c2h_ready, 0);
    rd(5'h04, v);
    check("R9 control W flag", v, {VER, 26'h0, 2'b10});
    check("R9 control read keeps flag", c2h_ready, 0);
    @(negedge clk) c2h_valid = 1; c2h_data = 32'h0000_9999;
    @(negedge clk) c2h_valid = 0;
    check("R9 push blocked while full", c2h_ready, 0);
    scan(32'h0, 5'h05, 1'b0, g);
    check("R9 data read consumes", c2h_ready, 1);
    scan(32'h0, 5'h04, 1'b0, g);
    check("R9 consumed word", g[31:0], 32'h0000_1357);
    scan(32'h0, 5'h04, 1'b0, g);
    check("R9 W flag cleared", g[31:0], {VER, 28'h0});
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v);
    check("R7 control write ignored", v, {VER, 28'h0});
  endtask

  task automatic t_reset_again;
    logic [37:0] g;
    wr(5'h05, 32'h1);
    do_reset();
    check("R11 flags after mid-run reset", {h2c_valid, c2h_ready}, 2'b01);
    check("R11 ctrl after mid-run reset", dbg_ctrl, 0);
    scan(32'h0, 5'h04, 1'b0, g);
    check("R11 read buffer cleared", g, 38'h0);
  endtask

  initial begin
    t_reset();
    t_frame();
    t_watch();
    t_ctrl();
    t_status();
    t_unmapped();
    t_h2c();
    t_c2h();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule